// File: doc/BRIEF.md
# Bus Ownership Arbiter with Hold, Address Hold and Backoff

This block decides, clock by clock, who owns the external bus of a bus-master interface. It accepts three kinds of ownership request from outside: a full hold request that asks for the whole bus and is answered with an acknowledge, an address-only hold that floats just the address group so that another agent can present a snoop address, and a backoff that seizes the bus at once, even in the middle of a transfer, with no acknowledge. It drives two output-enable controls, one for the address group and one for the rest of the bus, and it raises the hold acknowledge.

The arbiter also tracks the bus cycle in flight on behalf of the cycle sequencer. It tells the sequencer when a new cycle may start, pulses a restart line when a backoff cut a cycle short, and pulses a boundary line when a cycle or burst has ended normally. A lock input from the sequencer marks an atomic run of cycles, during which full hold is deferred. While the address group is floated, a low external-address-valid input produces a one-clock invalidation strobe for the cache.

All outputs other than the start permission come from registers, so they respond in the clock after the inputs that cause them are sampled.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A high `ahold_req` sampled at a clock edge makes `addr_oe` low from that edge on; `bus_oe` is not affected by `ahold_req`, and a cycle in flight continues and can still end.
- R2: A high `backoff_req` sampled at an edge makes `bus_oe` and `addr_oe` low and `hold_ack` low after that edge; the bus stays floated for as long as `backoff_req` is sampled high, and is driven again after the first edge at which it is sampled low.
- R3: When `backoff_req` is sampled high while a cycle is in flight, it wins over `rdy` and `brdy` in the same clock: the cycle is dropped, `restart` is high for exactly the next clock, and `boundary` stays low.
- R4: `hold_ack` rises only at an edge where `hold_req` is high, `lock_in` is low, `backoff_req` is low and no cycle remains in flight after that edge; it rises together with both enables falling, and falls together with both enables rising after the first edge where `hold_req` is sampled low.
- R5: While `lock_in` is high, a full hold is not granted, but an address-only hold is still honoured.
- R6: A cycle starts at an edge where `cyc_start` and `start_allow` are high. `rdy` and `brdy` are ignored when no cycle is in flight and at the edge that ends the cycle's first clock. At a later edge, `rdy` high ends the cycle; `brdy` high ends it only with `cyc_last` high and otherwise counts one burst beat. An ended cycle gives `boundary` high for exactly the next clock.
- R7: `start_allow` is high only when the bus is driven by this master, no cycle is in flight, `backoff_req` is low, and no grantable hold is waiting (`hold_req` high with `lock_in` low); `cyc_start` without it is ignored.
- R8: `inval_stb` is high for the clock after each edge at which `ext_av_n` is sampled low while the address group was already floated by address hold.
- R9: With both `backoff_req` and `hold_req` pending, backoff is served first; `hold_ack` can rise no earlier than the second edge after `backoff_req` is sampled low.
- R10: After reset, `bus_oe` and `addr_oe` are high and `hold_ack`, `restart`, `boundary` and `inval_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_req | input | 1 | Full bus hold request, active high |
| ahold_req | input | 1 | Address-only hold request, active high |
| backoff_req | input | 1 | Immediate backoff request, active high |
| ext_av_n | input | 1 | External address valid, active low |
| lock_in | input | 1 | Atomic cycle run in progress, from the sequencer |
| cyc_start | input | 1 | Sequencer issues a cycle's address phase this clock |
| cyc_last | input | 1 | Current beat is the last of the burst |
| rdy | input | 1 | Non-burst ready, active high |
| brdy | input | 1 | Burst ready, active high |
| hold_ack | output | 1 | Full hold acknowledged |
| bus_oe | output | 1 | Enable for the non-address bus group |
| addr_oe | output | 1 | Enable for the address group |
| start_allow | output | 1 | Sequencer may start a cycle this clock |
| restart | output | 1 | One-clock pulse: the cycle in flight was abandoned |
| boundary | output | 1 | One-clock pulse: a cycle or burst ended normally |
| inval_stb | output | 1 | One-clock cache invalidation strobe |

## Verification
The hardest case to reach is a backoff arriving in the same clock as the final burst ready of a locked burst while a full hold is also waiting, because it needs a cycle in its data phase, the right beat, the lock and two requests to line up in one clock. The bench reaches it with a directed sequence that starts a locked burst, counts beats, and raises backoff, hold and burst ready together on the last beat; it then releases backoff and lock and checks when the acknowledge arrives. A long stretch of biased random traffic follows, compared clock by clock against a behavioural model, to cover address hold during data transfer and snoop strobes under every ownership state.

// File: rtl/bha_pkg.sv
// Shared types for the bus ownership arbiter.
// Assumes: nothing beyond the enumerations below.
package bha_pkg;

    // Who drives the bus.
    typedef enum logic [1:0] {
        OWN_RUN  = 2'd0,   // this master drives the bus
        OWN_HOLD = 2'd1,   // bus granted away, acknowledge high
        OWN_BOFF = 2'd2    // bus seized by backoff, no acknowledge
    } own_e;

    // Progress of the bus cycle in flight.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,    // no cycle
        PH_ADDR = 2'd1,    // first clock of a cycle, readies ignored
        PH_DATA = 2'd2     // data clocks, readies honoured
    } phase_e;

endpackage

// File: rtl/bha_cycle_track.sv
// Tracks the bus cycle in flight and reports its endings.
// A cycle starts when the sequencer starts one and is allowed to; its first
// clock ignores the readies; later clocks end on rdy, or on brdy with the
// last-beat flag. A backoff drops the cycle and asks for a restart.
// Assumes: start_ok is already low while backoff is requested.
module bha_cycle_track
    import bha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic cyc_start,
    input  logic cyc_last,
    input  logic rdy,
    input  logic brdy,
    input  logic backoff,
    output logic cyc_idle,
    output logic ends_now,
    output logic restart,
    output logic boundary
);

    phase_e phase_q;
    phase_e phase_d;

    // Normal termination of a cycle in its data phase this clock.
    always_comb begin
        ends_now = (phase_q == PH_DATA) && (rdy || (brdy && cyc_last));
    end

    // Next phase, with backoff taking priority over every ready.
    always_comb begin
        phase_d = phase_q;
        if (backoff) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: phase_d = (start_ok && cyc_start) ? PH_ADDR : PH_IDLE;
                PH_ADDR: phase_d = PH_DATA;
                PH_DATA: phase_d = ends_now ? PH_IDLE : PH_DATA;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // One-clock restart and boundary pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart  <= 1'b0;
            boundary <= 1'b0;
        end else begin
            restart  <= backoff && (phase_q != PH_IDLE);
            boundary <= !backoff && ends_now;
        end
    end

    assign cyc_idle = (phase_q == PH_IDLE);

endmodule

// File: rtl/bha_own_fsm.sv
// Ownership state machine: running, held (acknowledged) or backed off.
// Backoff overrides everything; full hold waits for an idle bus and a low
// lock; leaving backoff always passes through running first.
// Assumes: cyc_idle and ends_now come from the cycle tracker.
module bha_own_fsm
    import bha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic lock_in,
    input  logic backoff,
    input  logic cyc_idle,
    input  logic ends_now,
    output logic start_ok,
    output logic hold_ack,
    output logic bus_oe
);

    own_e own_q;
    own_e own_d;
    logic hold_grantable;

    // A hold that could be granted as soon as the bus goes idle.
    assign hold_grantable = hold_req && !lock_in;

    // Permission for the sequencer to open a new cycle this clock.
    always_comb begin
        start_ok = (own_q == OWN_RUN) && cyc_idle && !backoff && !hold_grantable;
    end

    // Next ownership state.
    always_comb begin
        own_d = own_q;
        if (backoff) begin
            own_d = OWN_BOFF;
        end else begin
            unique case (own_q)
                OWN_RUN:  if (hold_grantable && (cyc_idle || ends_now)) own_d = OWN_HOLD;
                OWN_HOLD: if (!hold_req) own_d = OWN_RUN;
                OWN_BOFF: own_d = OWN_RUN;
                default:  own_d = OWN_RUN;
            endcase
        end
    end

    // Ownership register.
    always_ff @(posedge clk) begin
        if (!rst_n) own_q <= OWN_RUN;
        else        own_q <= own_d;
    end

    assign hold_ack = (own_q == OWN_HOLD);
    assign bus_oe   = (own_q == OWN_RUN);

endmodule

// File: rtl/bha_addr_hold.sv
// Address-only hold and snoop strobe.
// The address group floats the clock after the request is sampled, and
// whenever the whole bus is floated. A low external-address-valid seen while
// address hold was already in force yields a one-clock invalidation strobe.
// Assumes: bus_oe is the registered enable of the remaining bus group.
module bha_addr_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic ahold_req,
    input  logic ext_av_n,
    input  logic bus_oe,
    output logic addr_oe,
    output logic inval_stb
);

    logic ahold_q;

    // Sampled address hold request.
    always_ff @(posedge clk) begin
        if (!rst_n) ahold_q <= 1'b0;
        else        ahold_q <= ahold_req;
    end

    // Invalidation strobe, one clock per qualifying sample.
    always_ff @(posedge clk) begin
        if (!rst_n) inval_stb <= 1'b0;
        else        inval_stb <= ahold_q && !ext_av_n;
    end

    assign addr_oe = bus_oe && !ahold_q;

endmodule

// File: rtl/bus_hold_arbiter.sv
// Top of the bus ownership arbiter: joins the cycle tracker, the ownership
// state machine and the address-hold logic.
// Assumes: all inputs are synchronous to clk; rdy/brdy/hold/backoff are
// active high, ext_av_n is active low.
module bus_hold_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic ahold_req,
    input  logic backoff_req,
    input  logic ext_av_n,
    input  logic lock_in,
    input  logic cyc_start,
    input  logic cyc_last,
    input  logic rdy,
    input  logic brdy,
    output logic hold_ack,
    output logic bus_oe,
    output logic addr_oe,
    output logic start_allow,
    output logic restart,
    output logic boundary,
    output logic inval_stb
);

    logic cyc_idle;
    logic ends_now;

    bha_cycle_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_allow),
        .cyc_start(cyc_start),
        .cyc_last (cyc_last),
        .rdy      (rdy),
        .brdy     (brdy),
        .backoff  (backoff_req),
        .cyc_idle (cyc_idle),
        .ends_now (ends_now),
        .restart  (restart),
        .boundary (boundary)
    );

    bha_own_fsm u_own (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_req (hold_req),
        .lock_in  (lock_in),
        .backoff  (backoff_req),
        .cyc_idle (cyc_idle),
        .ends_now (ends_now),
        .start_ok (start_allow),
        .hold_ack (hold_ack),
        .bus_oe   (bus_oe)
    );

    bha_addr_hold u_ahold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ahold_req(ahold_req),
        .ext_av_n (ext_av_n),
        .bus_oe   (bus_oe),
        .addr_oe  (addr_oe),
        .inval_stb(inval_stb)
    );

endmodule

// File: rtl/bha_checker.sv
// Property checker for bus_hold_arbiter, attached by bind.
// Assumes: port names equal to the top module's.
module bha_checker (
    input logic clk,
    input logic rst_n,
    input logic hold_req,
    input logic ahold_req,
    input logic backoff_req,
    input logic ext_av_n,
    input logic lock_in,
    input logic cyc_start,
    input logic cyc_last,
    input logic rdy,
    input logic brdy,
    input logic hold_ack,
    input logic bus_oe,
    input logic addr_oe,
    input logic start_allow,
    input logic restart,
    input logic boundary,
    input logic inval_stb
);

    // R1
    ahold_floats_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ahold_req |=> !addr_oe);

    // R2
    backoff_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backoff_req |=> (!bus_oe && !addr_oe && !hold_ack));

    // R3
    restart_not_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !boundary);

    // R4
    ack_means_floated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!bus_oe && !addr_oe));

    // R5
    lock_blocks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_in && !hold_ack) |=> !hold_ack);

    // R6
    boundary_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> $past(rdy || brdy));

    // R7
    start_only_when_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_allow |-> (bus_oe && !hold_ack && !backoff_req));

    // R8
    inval_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_stb |-> $past(!ext_av_n));

    // R9
    backoff_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backoff_req && hold_req) |=> !hold_ack);

endmodule

bind bus_hold_arbiter bha_checker u_bha_chk (.*);

// File: tb/tb_bus_hold_arbiter.sv
`timescale 1ns/100ps
module tb_bus_hold_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req = 0, ahold_req = 0, backoff_req = 0, ext_av_n = 1;
    logic lock_in = 0, cyc_start = 0, cyc_last = 0, rdy = 0, brdy = 0;
    logic hold_ack, bus_oe, addr_oe, start_allow, restart, boundary, inval_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit armed = 0;
    bit finished = 0;

    // Behavioural reference state: 0 run, 1 held, 2 backed off; phase 0 idle, 1 first clock, 2 data.
    int m_own = 0, m_ph = 0;
    bit m_ah = 0, m_inv = 0, m_rst = 0, m_bnd = 0;

    always #2.5 clk = ~clk;

    bus_hold_arbiter dut (.*);

    function automatic bit m_start_ok();
        return (m_own == 0) && (m_ph == 0) && !backoff_req && !(hold_req && !lock_in);
    endfunction

    // Reference model update on every rising edge.
    always @(posedge clk) begin
        bit done, ok;
        if (!rst_n) begin
            m_own = 0; m_ph = 0; m_ah = 0; m_inv = 0; m_rst = 0; m_bnd = 0;
        end else begin
            done = (m_ph == 2) && (rdy || (brdy && cyc_last));
            ok   = m_start_ok();
            m_rst = backoff_req && (m_ph != 0);
            m_bnd = !backoff_req && done;
            m_inv = m_ah && !ext_av_n;
            m_ah  = ahold_req;
            if (backoff_req) m_own = 2;
            else if (m_own == 0) begin
                if (hold_req && !lock_in && (m_ph == 0 || done)) m_own = 1;
            end else if (m_own == 1) begin
                if (!hold_req) m_own = 0;
            end else m_own = 0;
            if (backoff_req) m_ph = 0;
            else if (m_ph == 0) m_ph = (ok && cyc_start) ? 1 : 0;
            else if (m_ph == 1) m_ph = 2;
            else if (done) m_ph = 0;
        end
    end

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    // Registered outputs compared on every falling edge, before new inputs.
    always @(negedge clk) begin
        if (armed) begin
            chk("R4", "hold_ack", hold_ack, m_own == 1);
            chk("R2", "bus_oe", bus_oe, m_own == 0);
            chk("R1", "addr_oe", addr_oe, (m_own == 0) && !m_ah);
            chk("R3", "restart", restart, m_rst);
            chk("R6", "boundary", boundary, m_bnd);
            chk("R8", "inval_stb", inval_stb, m_inv);
        end
    end

    // Drive a set of inputs after the falling edge, then check start_allow (R7).
    task automatic step(input bit h, input bit ah, input bit bo, input bit av_n,
                        input bit lk, input bit st, input bit ls, input bit r, input bit br);
        @(negedge clk);
        #0.5;
        hold_req = h; ahold_req = ah; backoff_req = bo; ext_av_n = av_n;
        lock_in = lk; cyc_start = st; cyc_last = ls; rdy = r; brdy = br;
        #0.5;
        if (armed) chk("R7", "start_allow", start_allow, m_start_ok());
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0,0,0,1,0,0,0,0,0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        armed = 1;
        // R10: reset values
        @(negedge clk);
        chk("R10", "bus_oe", bus_oe, 1'b1);
        chk("R10", "addr_oe", addr_oe, 1'b1);
        chk("R10", "hold_ack", hold_ack, 1'b0);
        chk("R10", "pulses", restart | boundary | inval_stb, 1'b0);

        // R6: single cycle, ready in first clock ignored, then ends
        step(0,0,0,1,0,1,0,0,0);
        step(0,0,0,1,0,0,0,1,0);
        step(0,0,0,1,0,0,0,1,0);
        idle(2);
        // R6: burst, three beats without last, then last
        step(0,0,0,1,0,1,0,0,0);
        for (int i = 0; i < 3; i++) step(0,0,0,1,0,0,0,0,1);
        step(0,0,0,1,0,0,1,0,1);
        idle(2);
        // R1/R8: address hold during a cycle, ready completes, snoop strobe
        step(0,0,0,1,0,1,0,0,0);
        step(0,1,0,1,0,0,0,0,0);
        step(0,1,0,0,0,0,0,1,0);
        step(0,1,0,0,0,0,0,0,0);
        step(0,0,0,1,0,0,0,0,0);
        idle(2);
        // R4: hold during a cycle waits for its end, then release
        step(0,0,0,1,0,1,0,0,0);
        step(1,0,0,1,0,0,0,0,0);
        step(1,0,0,1,0,0,0,0,0);
        step(1,0,0,1,0,0,1,0,1);
        step(1,0,0,1,0,0,0,0,0);
        step(0,0,0,1,0,0,0,0,0);
        idle(2);
        // R5: locked run refuses hold, address hold still taken
        step(1,0,0,1,1,1,0,0,0);
        step(1,1,0,1,1,0,0,1,0);
        step(1,1,0,0,1,0,0,0,0);
        step(1,0,0,1,1,0,0,0,0);
        step(1,0,0,1,0,0,0,0,0);
        step(1,0,0,1,0,0,0,0,0);
        idle(2);
        // R3/R9: backoff with last burst ready, locked, hold pending
        step(0,0,0,1,1,1,0,0,0);
        step(0,0,0,1,1,0,0,0,1);
        step(1,0,1,1,1,0,1,0,1);
        step(1,0,1,1,1,0,0,0,0);
        step(1,0,0,1,0,0,0,0,0);
        step(1,0,0,1,0,0,0,0,0);
        step(1,0,0,1,0,0,0,0,0);
        step(0,0,0,1,0,0,0,0,0);
        idle(2);
        // R2: backoff with no cycle, held several clocks
        step(0,0,1,1,0,0,0,0,0);
        step(0,0,1,1,0,1,0,0,0);
        step(0,0,1,1,0,0,0,0,0);
        idle(3);
        // Random traffic across all requirements
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 8) == 0 ? ~hold_req : hold_req,
                 ($urandom % 6) == 0 ? ~ahold_req : ahold_req,
                 ($urandom % 20) == 0 ? ~backoff_req : backoff_req,
                 ($urandom % 3) != 0,
                 ($urandom % 10) == 0 ? ~lock_in : lock_in,
                 ($urandom % 2) == 0,
                 ($urandom % 3) == 0,
                 ($urandom % 5) == 0,
                 ($urandom % 3) == 0);
        end
        idle(3);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule